// File: doc/BRIEF.md
# USB Host Error Tracking and Interrupt Controller

This block is the error and interrupt corner of a frame-based full-speed USB host. It watches the received bit stream for stuffing violations, counts transaction errors against the error budget of the transfer descriptor currently in service, and retires that descriptor as stalled once the budget runs out. Errors that only stall a descriptor are reported lazily: their status bit is raised at the end-of-frame strobe. Fatal conditions do not wait. A descriptor that fails its sanity check, or a bus fault on the memory side, stops the schedule in the next cycle and drives an interrupt that no enable bit can mask.

A small register port replaces the serial engine, the DMA and the list walker. A descriptor load seeds the error budget and marks the descriptor active. Software writes the command, status and enable registers through a one-cycle write strobe. The received bit stream arrives as a valid-qualified serial input with no ready signal. The block accepts one bit in every cycle where `rx_valid` is high, so it never applies back-pressure, and the sender must hold `rx_valid` low in cycles that carry no bit.

Top module: `usb_irq_err_ctl`

## Requirements
- R1: After reset, `run_stop` is 0, `halted` is 1, `status` and `int_en` are 0, `irq` is 0, and the descriptor is neither active nor stalled.
- R2: `td_load` sets `td_cerr` to `td_cerr_init`, sets active and clears stalled. While the descriptor is active with a nonzero count, a cycle with `buf_err` or a stuffing error lowers the count by exactly one, even when both occur in the same cycle. A count of 0 means no limit: errors leave it unchanged.
- R3: A stuffing error is the seventh consecutive 1 in the accepted bits. The run of ones restarts at every accepted 0 and at every bit marked `rx_sop`, where the marked bit itself starts the new run. The run also restarts after each error.
- R4: When the count steps from 1 to 0, the descriptor becomes inactive and stalled in the same edge. `status[0]` (usb error) is not raised then. It is raised at the first `eof` strobe at or after that cycle.
- R5: A `chk_valid` cycle whose PID is not 0x69, 0xE1 or 0x2D, or whose max length is 1280 or more, sets `status[3]` (process error), clears `run_stop` and sets `halted` on the next edge.
- R6: A cycle with `parity_err`, `master_abort` or `target_abort` sets `status[2]` (host system error) and clears `run_stop` on the next edge.
- R7: `irq` is `(status[0] & int_en[0]) | (status[1] & int_en[1]) | status[2] | status[3]`, so the two fatal bits ignore the enables.
- R8: `resume_det` sets `status[1]` only while `suspended` is 1. Otherwise the pulse has no effect.
- R9: A write to address 1 clears each status bit whose data bit is 1 and leaves the others alone. A bit that is being set in the same cycle stays set.
- R10: A write to address 0 loads `run_stop` from data bit 0. `halted` follows the inverse of that bit. A fault in the same cycle overrides a write of 1. A write to address 2 loads `int_en` from data bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_sop | input | 1 | The present bit is the first of a packet |
| rx_bit | input | 1 | Received bit value |
| buf_err | input | 1 | Buffer overrun or underrun on the current transaction |
| td_load | input | 1 | Load a new descriptor |
| td_cerr_init | input | 2 | Error budget of the loaded descriptor |
| td_cerr | output | 2 | Remaining error budget |
| td_active | output | 1 | Descriptor active flag |
| td_stalled | output | 1 | Descriptor stalled flag |
| chk_valid | input | 1 | Descriptor fields presented for checking |
| chk_pid | input | 8 | Descriptor PID byte |
| chk_maxlen | input | 11 | Descriptor max length field |
| parity_err | input | 1 | Bus parity fault |
| master_abort | input | 1 | Bus master abort |
| target_abort | input | 1 | Bus target abort |
| suspended | input | 1 | Bus is in global suspend |
| resume_det | input | 1 | Resume signalling seen on the bus |
| eof | input | 1 | End-of-frame strobe |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 2 | Register address: 0 command, 1 status, 2 enable |
| sw_wdata | input | 4 | Register write data |
| run_stop | output | 1 | Schedule run control |
| halted | output | 1 | Controller halted |
| status | output | 4 | Status: 0 usb error, 1 resume, 2 host system error, 3 process error |
| int_en | output | 2 | Enables: 0 usb error, 1 resume |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can meet in one cycle. First, the budget can run out in the same cycle as the end-of-frame strobe. Second, the deferred error flag or a fault can be set in the same cycle that software writes 1 to clear it. The bench drives both cases directly: a single error pulse together with `eof`, and an `eof` or fault pulse together with a status clear or a run write. It expects the status bit to be set, and a fault to win over run. Random descriptor budgets and random error trains are compared against a bench model of the countdown and of the masked interrupt.

// File: rtl/usb_ie_pkg.sv
package usb_ie_pkg;
  localparam int ST_USBERR = 0;
  localparam int ST_RESUME = 1;
  localparam int ST_HSE    = 2;
  localparam int ST_PROC   = 3;
  localparam int ST_W      = 4;
  localparam int EN_W      = 2;

  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  typedef enum logic [1:0] {
    REG_CMD    = 2'd0,
    REG_STATUS = 2'd1,
    REG_IEN    = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/usb_bitstuff_mon.sv
module usb_bitstuff_mon #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_sop,
  input  logic rx_bit,
  output logic stuff_err
);
  localparam int CNT_W = $clog2(STUFF_RUN + 1);

  logic [CNT_W-1:0] ones_q;

  assign stuff_err = rx_valid && rx_bit && !rx_sop && (ones_q == CNT_W'(STUFF_RUN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (rx_valid) begin
      if (rx_sop)         ones_q <= rx_bit ? CNT_W'(1) : '0;
      else if (!rx_bit)   ones_q <= '0;
      else if (stuff_err) ones_q <= '0;
      else                ones_q <= ones_q + 1'b1;
    end
  end

  AST_ZERO_BREAKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_bit) |=> !stuff_err); // R3
endmodule

// File: rtl/usb_td_errcnt.sv
module usb_td_errcnt #(
  parameter int CERR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CERR_W-1:0] cerr_init,
  input  logic              err,
  input  logic              eof,
  output logic [CERR_W-1:0] cerr,
  output logic              active,
  output logic              stalled,
  output logic              eof_flag
);
  logic pend_q;
  logic dec;
  logic hit;

  assign dec      = !load && err && active && (cerr != '0);
  assign hit      = dec && (cerr == CERR_W'(1));
  assign eof_flag = eof && (pend_q || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cerr    <= '0;
      active  <= 1'b0;
      stalled <= 1'b0;
    end else if (load) begin
      cerr    <= cerr_init;
      active  <= 1'b1;
      stalled <= 1'b0;
    end else if (dec) begin
      cerr <= cerr - 1'b1;
      if (hit) begin
        active  <= 1'b0;
        stalled <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (eof) pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
  end

  AST_STALL_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !active); // R4
  AST_SINGLE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && err && active && cerr != '0) |=> (cerr == $past(cerr) - 1'b1)); // R2
endmodule

// File: rtl/usb_desc_check.sv
module usb_desc_check #(
  parameter int MAXLEN_W     = 11,
  parameter int MAXLEN_LIMIT = 1280
) (
  input  logic                chk_valid,
  input  logic [7:0]          chk_pid,
  input  logic [MAXLEN_W-1:0] chk_maxlen,
  output logic                proc_err
);
  import usb_ie_pkg::*;

  logic pid_ok;
  logic len_ok;

  always_comb begin
    pid_ok = (chk_pid == PID_IN) || (chk_pid == PID_OUT) || (chk_pid == PID_SETUP);
    len_ok = chk_maxlen < MAXLEN_W'(MAXLEN_LIMIT);
    proc_err = chk_valid && !(pid_ok && len_ok);
  end
endmodule

// File: rtl/usb_irq_err_ctl.sv
module usb_irq_err_ctl
  import usb_ie_pkg::*;
#(
  parameter int CERR_W       = 2,
  parameter int STUFF_RUN    = 6,
  parameter int MAXLEN_W     = 11,
  parameter int MAXLEN_LIMIT = 1280
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic                rx_sop,
  input  logic                rx_bit,
  input  logic                buf_err,
  input  logic                td_load,
  input  logic [CERR_W-1:0]   td_cerr_init,
  output logic [CERR_W-1:0]   td_cerr,
  output logic                td_active,
  output logic                td_stalled,
  input  logic                chk_valid,
  input  logic [7:0]          chk_pid,
  input  logic [MAXLEN_W-1:0] chk_maxlen,
  input  logic                parity_err,
  input  logic                master_abort,
  input  logic                target_abort,
  input  logic                suspended,
  input  logic                resume_det,
  input  logic                eof,
  input  logic                sw_wr,
  input  logic [1:0]          sw_addr,
  input  logic [ST_W-1:0]     sw_wdata,
  output logic                run_stop,
  output logic                halted,
  output logic [ST_W-1:0]     status,
  output logic [EN_W-1:0]     int_en,
  output logic                irq
);
  logic stuff_err;
  logic proc_err;
  logic usberr_set;
  logic hse_set;
  logic fault;
  logic wr_cmd, wr_sts, wr_ien;
  logic [ST_W-1:0] sts_set;
  logic [ST_W-1:0] sts_clr;

  usb_bitstuff_mon #(.STUFF_RUN(STUFF_RUN)) stuff_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_bit(rx_bit), .stuff_err(stuff_err)
  );

  usb_td_errcnt #(.CERR_W(CERR_W)) td_i (
    .clk(clk), .rst_n(rst_n), .load(td_load), .cerr_init(td_cerr_init),
    .err(buf_err || stuff_err), .eof(eof), .cerr(td_cerr),
    .active(td_active), .stalled(td_stalled), .eof_flag(usberr_set)
  );

  usb_desc_check #(.MAXLEN_W(MAXLEN_W), .MAXLEN_LIMIT(MAXLEN_LIMIT)) chk_i (
    .chk_valid(chk_valid), .chk_pid(chk_pid), .chk_maxlen(chk_maxlen),
    .proc_err(proc_err)
  );

  always_comb begin
    hse_set = parity_err || master_abort || target_abort;
    fault   = hse_set || proc_err;
    wr_cmd  = sw_wr && (sw_addr == REG_CMD);
    wr_sts  = sw_wr && (sw_addr == REG_STATUS);
    wr_ien  = sw_wr && (sw_addr == REG_IEN);
    sts_set            = '0;
    sts_set[ST_USBERR] = usberr_set;
    sts_set[ST_RESUME] = resume_det && suspended;
    sts_set[ST_HSE]    = hse_set;
    sts_set[ST_PROC]   = proc_err;
    sts_clr = wr_sts ? sw_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      int_en <= '0;
    end else begin
      status <= (status & ~sts_clr) | sts_set;
      if (wr_ien) int_en <= sw_wdata[EN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_stop <= 1'b0;
      halted   <= 1'b1;
    end else if (fault) begin
      run_stop <= 1'b0;
      halted   <= 1'b1;
    end else if (wr_cmd) begin
      run_stop <= sw_wdata[0];
      halted   <= !sw_wdata[0];
    end
  end

  assign irq = (status[ST_USBERR] && int_en[0]) || (status[ST_RESUME] && int_en[1])
             || status[ST_HSE] || status[ST_PROC];

  AST_PROC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    proc_err |=> (halted && !run_stop && status[ST_PROC])); // R5
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    hse_set |=> (!run_stop && status[ST_HSE])); // R6
  AST_FATAL_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_HSE] || status[ST_PROC]) |-> irq); // R7
  AST_CLEAR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && sw_wdata[ST_RESUME] && !(resume_det && suspended)) |=> !status[ST_RESUME]); // R9
endmodule

// File: tb/usb_irq_err_ctl_tb_top.sv
module usb_irq_err_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sop = 0, rx_bit = 0, buf_err = 0, td_load = 0;
  logic [1:0] td_cerr_init = '0;
  logic [1:0] td_cerr;
  logic td_active, td_stalled;
  logic chk_valid = 0;
  logic [7:0] chk_pid = '0;
  logic [10:0] chk_maxlen = '0;
  logic parity_err = 0, master_abort = 0, target_abort = 0;
  logic suspended = 0, resume_det = 0, eof = 0, sw_wr = 0;
  logic [1:0] sw_addr = '0;
  logic [3:0] sw_wdata = '0;
  logic run_stop, halted, irq;
  logic [3:0] status;
  logic [1:0] int_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_irq_err_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_bit(rx_bit),
    .buf_err(buf_err), .td_load(td_load), .td_cerr_init(td_cerr_init),
    .td_cerr(td_cerr), .td_active(td_active), .td_stalled(td_stalled),
    .chk_valid(chk_valid), .chk_pid(chk_pid), .chk_maxlen(chk_maxlen),
    .parity_err(parity_err), .master_abort(master_abort), .target_abort(target_abort),
    .suspended(suspended), .resume_det(resume_det), .eof(eof),
    .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .run_stop(run_stop), .halted(halted), .status(status), .int_en(int_en), .irq(irq)
  );

  function automatic logic exp_irq(logic [3:0] s, logic [1:0] e);
    return (s[0] & e[0]) | (s[1] & e[1]) | s[2] | s[3];
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_bit = 0; buf_err = 0; td_load = 0;
    chk_valid = 0; parity_err = 0; master_abort = 0; target_abort = 0;
    resume_det = 0; eof = 0; sw_wr = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    sw_wr = 1; sw_addr = a; sw_wdata = d; step();
  endtask

  task automatic load(logic [1:0] c);
    td_load = 1; td_cerr_init = c; step();
  endtask

  task automatic rxb(logic s, logic b);
    rx_valid = 1; rx_sop = s; rx_bit = b; step();
  endtask

  task automatic desc(logic [7:0] p, logic [10:0] l);
    chk_valid = 1; chk_pid = p; chk_maxlen = l; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset values
    check("R1 run", run_stop, 0); check("R1 halted", halted, 1);
    check("R1 status", status, 0); check("R1 int_en", int_en, 0);
    check("R1 irq", irq, 0); check("R1 active", td_active, 0); check("R1 stalled", td_stalled, 0);

    // R2 load and decrement, both errors together count once
    load(2'd3); check("R2 load cerr", td_cerr, 3); check("R2 load active", td_active, 1);
    buf_err = 1; step(); check("R2 dec", td_cerr, 2);
    for (int i = 0; i < 6; i++) rxb(i == 0, 1'b1);
    buf_err = 1; rxb(1'b0, 1'b1); check("R2 double error once", td_cerr, 1);
    load(2'd0); buf_err = 1; step(); check("R2 zero budget unlimited", td_cerr, 0);
    check("R2 zero budget active", td_active, 1);

    // R3 bit stuffing
    load(2'd3);
    rxb(1'b1, 1'b1); for (int i = 0; i < 6; i++) rxb(1'b0, 1'b1);
    check("R3 seventh one", td_cerr, 2);
    for (int i = 0; i < 6; i++) rxb(1'b0, 1'b1);
    rxb(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) rxb(1'b0, 1'b1);
    check("R3 zero restarts run", td_cerr, 2);
    rxb(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) rxb(1'b0, 1'b1);
    rxb(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) rxb(1'b0, 1'b1);
    check("R3 sop restarts run", td_cerr, 2);
    rxb(1'b0, 1'b1); check("R3 run after sop", td_cerr, 1);

    // R4 stall and deferred status
    buf_err = 1; step();
    check("R4 cerr zero", td_cerr, 0); check("R4 inactive", td_active, 0);
    check("R4 stalled", td_stalled, 1); check("R4 deferred", status[0], 0);
    step(); check("R4 still deferred", status[0], 0);
    eof = 1; step(); check("R4 set at eof", status[0], 1);
    check("R7 masked usb error", irq, 0);
    wr(2'd2, 4'b0001); check("R10 ien write", int_en, 1);
    check("R7 enabled usb error", irq, 1);
    wr(2'd1, 4'b0001); check("R9 w1c usb error", status[0], 0);
    load(2'd1); buf_err = 1; eof = 1; step();
    check("R4 same cycle eof", status[0], 1);
    wr(2'd1, 4'b1110); check("R9 other bits kept", status[0], 1);
    wr(2'd1, 4'b0001);
    load(2'd1); buf_err = 1; step();
    eof = 1; sw_wr = 1; sw_addr = 2'd1; sw_wdata = 4'b0001; step();
    check("R9 set beats clear", status[0], 1);
    wr(2'd1, 4'b1111);

    // R8 resume
    wr(2'd2, 4'b0000);
    suspended = 0; resume_det = 1; step(); check("R8 not suspended", status[1], 0);
    suspended = 1; resume_det = 1; step(); check("R8 suspended", status[1], 1);
    check("R8 irq masked", irq, 0);
    wr(2'd2, 4'b0010); check("R8 irq enabled", irq, 1);
    wr(2'd1, 4'b0010); check("R9 clear resume", status[1], 0);
    suspended = 0;

    // R5 process error
    wr(2'd0, 4'b0001); check("R10 run", run_stop, 1); check("R10 halted low", halted, 0);
    desc(8'h69, 11'd1279); check("R5 valid desc", status[3], 0); check("R5 still running", run_stop, 1);
    desc(8'h2D, 11'd1280); check("R5 maxlen", status[3], 1);
    check("R5 run cleared", run_stop, 0); check("R5 halted", halted, 1);
    wr(2'd2, 4'b0000); check("R7 proc unmaskable", irq, 1);
    wr(2'd1, 4'b1000); wr(2'd0, 4'b0001);
    desc(8'hA5, 11'd8); check("R5 bad pid", status[3], 1); check("R5 bad pid run", run_stop, 0);
    wr(2'd1, 4'b1000); wr(2'd0, 4'b0001);
    desc(8'hE1, 11'd0); check("R5 out pid ok", status[3], 0);

    // R6 bus faults
    target_abort = 1; step(); check("R6 hse", status[2], 1); check("R6 run cleared", run_stop, 0);
    check("R7 hse unmaskable", irq, 1);
    wr(2'd1, 4'b0100); check("R9 clear hse", status[2], 0);
    wr(2'd0, 4'b0001); master_abort = 1; step(); check("R6 master abort", status[2], 1);
    wr(2'd1, 4'b0100);
    parity_err = 1; sw_wr = 1; sw_addr = 2'd0; sw_wdata = 4'b0001; step();
    check("R10 fault beats run", run_stop, 0); check("R10 halted kept", halted, 1);
    wr(2'd1, 4'b0100);
    wr(2'd0, 4'b0001); wr(2'd0, 4'b0000);
    check("R10 stop", run_stop, 0); check("R10 halted on stop", halted, 1);

    // random descriptor budgets and error trains
    for (int it = 0; it < 40; it++) begin
      logic [1:0] c;
      logic act, st, hitf;
      logic [1:0] en;
      c = 2'($urandom_range(3, 0));
      load(c); act = 1; st = 0; hitf = 0;
      for (int k = 0; k < int'($urandom_range(4, 0)); k++) begin
        logic b;
        b = 1'($urandom_range(1, 0));
        buf_err = b; step();
        if (b && act && c != 0) begin
          c = c - 1;
          if (c == 0) begin act = 0; st = 1; hitf = 1; end
        end
      end
      check("R2 random cerr", td_cerr, c);
      check("R4 random active", td_active, act);
      check("R4 random stalled", td_stalled, st);
      eof = 1; step(); check("R4 random eof", status[0], hitf);
      en = 2'($urandom_range(3, 0));
      wr(2'd2, {2'b00, en});
      check("R7 random irq", irq, exp_irq(status, en));
      wr(2'd1, 4'b1111);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule